// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a flow-through synchronous SRAM that shares one data bus between reads and writes. All control inputs are registered on the rising clock edge. A read sends its data out combinationally in the cycle that follows the edge where it was issued. A write registers its address on one edge and takes its data and lane strobes on the next edge. Any mix of reads, writes and deselects can therefore be issued on every clock without idle cycles.

The captured write data waits in a holding register and goes into the array on the next edge that is not stalled. A read of that location in the meantime gets the held bytes merged over the array contents. An active-high clock-enable-low input stalls the whole block. The block makes the bus drive decision from its registered state and from an output-enable input that it does not register. Address stepping inside a burst belongs to an external sequencer. When a burst continuation edge is presented, this block raises a request for the next address. During continuation cycles the sequencer supplies that address on the address input.

Top module: `zt_sram`

## Requirements
- R1: After reset the block is deselected and `rdata_oe_o` is 0, whatever the level of `out_en_ni`.
- R2: A new access starts on an edge only when `clk_en_ni`=0, `adv_ld_ni`=0, `sel1_ni`=0, `sel2_i`=1 and `sel3_ni`=0. An edge with `clk_en_ni`=0 and `adv_ld_ni`=0 and any of the three selects inactive is a deselect, and the bus is off in the following cycle.
- R3: A write takes its address on the start edge, and takes `wdata_i` and `lane_wr_ni` on the next accepted edge. Lane 0 is bits [8:0] and is written only when `lane_wr_ni[0]`=0. Lane 1 is bits [17:9] and is written only when `lane_wr_ni[1]`=0. With both strobes at 1 no byte changes.
- R4: On the edge that takes a write's data, a new access can be issued. A read of the just-written location in the following cycle returns the new bytes merged with the old ones.
- R5: An edge with `clk_en_ni`=1 changes no state and no output. A write whose data edge is stalled takes its data on the next accepted edge instead.
- R6: During a write's data cycle `rdata_oe_o` is 0 even with `out_en_ni`=0.
- R7: In the cycle after the first access that follows a deselected state, `rdata_oe_o` is 0.
- R8: `out_en_ni` acts without a clock: during a read cycle `rdata_oe_o` follows its inverse within the same cycle.
- R9: An accepted edge with `adv_ld_ni`=1 continues the current burst. It keeps the read/write type and ignores `wr_ni` and the selects. It takes the next address from `addr_i`. When the block is deselected, such an edge keeps it deselected.
- R10: `burst_next_o` is 1 exactly when `clk_en_ni`=0, `adv_ld_ni`=1 and a burst is active.
- R11: Read data for the address issued on edge k is on `rdata_o` in the cycle between edge k and edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock qualifier, active low; high stalls |
| sel1_ni | input | 1 | Select, active low |
| sel2_i | input | 1 | Select, active high |
| sel3_ni | input | 1 | Select, active low |
| wr_ni | input | 1 | Write request at burst start, active low |
| lane_wr_ni | input | 2 | Lane write strobes, active low, sampled on data edge |
| adv_ld_ni | input | 1 | Low loads a new access, high continues burst |
| out_en_ni | input | 1 | Unclocked output enable, active low |
| addr_i | input | 4 | Word address |
| wdata_i | input | 18 | Write data, two 9-bit lanes |
| rdata_o | output | 18 | Flow-through read data |
| rdata_oe_o | output | 1 | Bus drive enable |
| burst_next_o | output | 1 | Request to sequencer for next burst address |

## Verification
A wrong access state shows on the bus within one cycle. A lost write type makes `rdata_oe_o` rise in a write data cycle, and a missed deselect leaves it high. A stale holding register or a bad bypass shows only when the written word is read. The bench therefore reads the written location on the very edge that takes the data, and reads it again after the commit. A stall that leaks through shows as a change of `rdata_o` or of the written word across the stalled edge.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [2:0] {
    CMD_HOLD,   // clock masked
    CMD_DESEL,  // load with a select inactive
    CMD_START,  // load new access
    CMD_NEXT,   // continue burst
    CMD_IDLE    // advance while deselected
  } cmd_e;
endpackage

// File: rtl/zt_cmd_dec.sv
module zt_cmd_dec
  import zt_sram_pkg::*;
(
  input  logic clk_en_ni,
  input  logic sel1_ni,
  input  logic sel2_i,
  input  logic sel3_ni,
  input  logic adv_ld_ni,
  input  logic burst_live_i,
  output cmd_e cmd_o
);
  logic selected;
  assign selected = !sel1_ni && sel2_i && !sel3_ni;

  always_comb begin
    if (clk_en_ni)       cmd_o = CMD_HOLD;
    else if (adv_ld_ni)  cmd_o = burst_live_i ? CMD_NEXT : CMD_IDLE;
    else if (selected)   cmd_o = CMD_START;
    else                 cmd_o = CMD_DESEL;
  end
endmodule

// File: rtl/zt_access_ctl.sv
module zt_access_ctl
  import zt_sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  output logic          acc_v_o,
  output logic          acc_wr_o,
  output logic [AW-1:0] addr_o,
  output logic          first_o
);
  logic desel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_v_o  <= 1'b0;
      acc_wr_o <= 1'b0;
      addr_o   <= '0;
      desel_q  <= 1'b1;
      first_o  <= 1'b0;
    end else begin
      unique case (cmd_i)
        CMD_START: begin
          acc_v_o  <= 1'b1;
          acc_wr_o <= !wr_ni;
          addr_o   <= addr_i;
          first_o  <= desel_q;
          desel_q  <= 1'b0;
        end
        CMD_NEXT: begin
          // type held from burst start
          addr_o  <= addr_i;
          first_o <= 1'b0;
        end
        CMD_DESEL, CMD_IDLE: begin
          acc_v_o  <= 1'b0;
          acc_wr_o <= 1'b0;
          desel_q  <= 1'b1;
          first_o  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/zt_wr_hold.sv
module zt_wr_hold #(
  parameter int AW     = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             cap_i,
  input  logic [AW-1:0]    cap_addr_i,
  input  logic [DW-1:0]    cap_data_i,
  input  logic [LANES-1:0] cap_lane_ni,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [DW-1:0]    rd_raw_i,
  output logic             commit_o,
  output logic [AW-1:0]    commit_addr_o,
  output logic [DW-1:0]    commit_data_o,
  output logic [LANES-1:0] commit_be_o,
  output logic [DW-1:0]    rd_data_o
);
  logic             hold_v;
  logic [AW-1:0]    hold_addr;
  logic [DW-1:0]    hold_data;
  logic [LANES-1:0] hold_be;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v    <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_be   <= '0;
    end else if (step_i) begin
      hold_v <= cap_i;
      if (cap_i) begin
        hold_addr <= cap_addr_i;
        hold_data <= cap_data_i;
        hold_be   <= ~cap_lane_ni;
      end
    end
  end

  assign commit_o      = step_i && hold_v;
  assign commit_addr_o = hold_addr;
  assign commit_data_o = hold_data;
  assign commit_be_o   = hold_be;
  assign hit           = hold_v && (hold_addr == rd_addr_i);

  // held bytes override array bytes lane by lane
  for (genvar l = 0; l < LANES; l++) begin : g_byp
    assign rd_data_o[l*LANE_W +: LANE_W] = (hit && hold_be[l]) ?
        hold_data[l*LANE_W +: LANE_W] : rd_raw_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [DW-1:0]    wd_i,
  input  logic [LANES-1:0] be_i,
  input  logic [AW-1:0]    ra_i,
  output logic [DW-1:0]    rd_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem[wa_i] <= wd_i[l*LANE_W +: LANE_W];
    end
    assign rd_o[l*LANE_W +: LANE_W] = mem[ra_i];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_ni,
  input  logic             sel1_ni,
  input  logic             sel2_i,
  input  logic             sel3_ni,
  input  logic             wr_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  input  logic             adv_ld_ni,
  input  logic             out_en_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_oe_o,
  output logic             burst_next_o
);
  cmd_e             cmd;
  logic             acc_v, acc_wr, first;
  logic [AW-1:0]    acc_addr;
  logic             step, cap;
  logic             commit;
  logic [AW-1:0]    commit_addr;
  logic [DW-1:0]    commit_data, raw_data;
  logic [LANES-1:0] commit_be;

  zt_cmd_dec u_dec (
    .clk_en_ni    (clk_en_ni),
    .sel1_ni      (sel1_ni),
    .sel2_i       (sel2_i),
    .sel3_ni      (sel3_ni),
    .adv_ld_ni    (adv_ld_ni),
    .burst_live_i (acc_v),
    .cmd_o        (cmd)
  );

  zt_access_ctl #(.AW(AW)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .wr_ni    (wr_ni),
    .addr_i   (addr_i),
    .acc_v_o  (acc_v),
    .acc_wr_o (acc_wr),
    .addr_o   (acc_addr),
    .first_o  (first)
  );

  assign step = (cmd != CMD_HOLD);
  assign cap  = step && acc_v && acc_wr;

  zt_wr_hold #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (step),
    .cap_i         (cap),
    .cap_addr_i    (acc_addr),
    .cap_data_i    (wdata_i),
    .cap_lane_ni   (lane_wr_ni),
    .rd_addr_i     (acc_addr),
    .rd_raw_i      (raw_data),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data),
    .commit_be_o   (commit_be),
    .rd_data_o     (rdata_o)
  );

  zt_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i (clk_i),
    .we_i  (commit),
    .wa_i  (commit_addr),
    .wd_i  (commit_data),
    .be_i  (commit_be),
    .ra_i  (acc_addr),
    .rd_o  (raw_data)
  );

  assign rdata_oe_o   = acc_v && !acc_wr && !first && !out_en_ni;
  assign burst_next_o = (cmd == CMD_NEXT);
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clk_en_ni,
  input logic          sel1_ni,
  input logic          sel2_i,
  input logic          sel3_ni,
  input logic          wr_ni,
  input logic          adv_ld_ni,
  input logic [DW-1:0] rdata_o,
  input logic          rdata_oe_o,
  input logic          acc_v,
  input logic          acc_wr
);
  logic [1:0] armed_q;
  logic       armed;
  logic       sel_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 2'd0;
    else if (!armed_q[1]) armed_q <= armed_q + 2'd1;
  end
  assign armed   = armed_q[1];
  assign sel_all = !sel1_ni && sel2_i && !sel3_ni;

  p_desel_hiz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(!clk_en_ni && !adv_ld_ni && !sel_all)) |-> !rdata_oe_o);

  p_wr_data_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(!clk_en_ni && !adv_ld_ni && sel_all && !wr_ni)) |-> !rdata_oe_o);

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(clk_en_ni)) |-> ($stable(rdata_o) && $stable(acc_v) && $stable(acc_wr)));

  p_burst_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(!clk_en_ni && adv_ld_ni && acc_v)) |->
      (acc_v && (acc_wr == $past(acc_wr))));
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_en_ni  (clk_en_ni),
  .sel1_ni    (sel1_ni),
  .sel2_i     (sel2_i),
  .sel3_ni    (sel3_ni),
  .wr_ni      (wr_ni),
  .adv_ld_ni  (adv_ld_ni),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o),
  .acc_v      (acc_v),
  .acc_wr     (acc_wr)
);

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int DW    = 18;
  localparam bit [2:0] SEL = 3'b010; // {sel1_ni, sel2_i, sel3_ni}

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clk_en_ni = 1'b0;
  logic          sel1_ni = 1'b1, sel2_i = 1'b0, sel3_ni = 1'b1;
  logic          wr_ni = 1'b1;
  logic [1:0]    lane_wr_ni = 2'b11;
  logic          adv_ld_ni = 1'b0;
  logic          out_en_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rdata_oe_o, burst_next_o;

  always #(CLK_P/2) clk = ~clk;

  zt_sram #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni),
    .sel1_ni(sel1_ni), .sel2_i(sel2_i), .sel3_ni(sel3_ni),
    .wr_ni(wr_ni), .lane_wr_ni(lane_wr_ni), .adv_ld_ni(adv_ld_ni),
    .out_en_ni(out_en_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o), .burst_next_o(burst_next_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_act = 0, m_wr = 0, m_desel = 1, m_first = 0;
  logic [AW-1:0] m_addr = '0;

  typedef struct {
    string         tag;
    bit            chk;
    bit            eoe;
    logic [DW-1:0] ed;
  } item_t;
  item_t sb[$];

  task automatic cyc(input bit cen_n, input bit [2:0] ce, input bit we_n,
                     input bit adv_n, input bit [1:0] bw_n, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit oe_n, input string tag,
                     input bit chk = 1'b1);
    item_t it;
    bit exp_bn;
    @(negedge clk);
    clk_en_ni = cen_n; {sel1_ni, sel2_i, sel3_ni} = ce; wr_ni = we_n;
    adv_ld_ni = adv_n; lane_wr_ni = bw_n; addr_i = a; wdata_i = d; out_en_ni = oe_n;
    exp_bn = !cen_n && adv_n && m_act;
    #1 check("R10 burst_next", 32'(burst_next_o), 32'(exp_bn));
    if (!cen_n) begin
      if (m_act && m_wr) begin
        if (!bw_n[0]) ref_mem[m_addr][8:0]  = d[8:0];
        if (!bw_n[1]) ref_mem[m_addr][17:9] = d[17:9];
      end
      if (adv_n) begin
        if (m_act) begin m_addr = a; m_first = 0; end
        else begin m_act = 0; m_wr = 0; m_desel = 1; m_first = 0; end
      end else if (ce == SEL) begin
        m_act = 1; m_wr = !we_n; m_addr = a; m_first = m_desel; m_desel = 0;
      end else begin
        m_act = 0; m_wr = 0; m_desel = 1; m_first = 0;
      end
    end
    it.tag = tag; it.chk = chk;
    it.eoe = m_act && !m_wr && !m_first && !oe_n;
    it.ed  = ref_mem[m_addr];
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        if (it.chk) begin
          check({it.tag, " oe"}, 32'(rdata_oe_o), 32'(it.eoe));
          if (it.eoe) check({it.tag, " data"}, 32'(rdata_o), 32'(it.ed));
        end
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(32'h1_1111 * (i + 1) ^ 32'h2_A05A);
  endfunction

  bit done = 0;
  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // reset, selects inactive
    repeat (3) @(negedge clk);
    check("R1 reset oe", 32'(rdata_oe_o), 32'd0);
    rst_ni = 1'b1;
    #1 check("R1 after release oe", 32'(rdata_oe_o), 32'd0);

    // fill 0..11, back-to-back writes, data trails by one edge
    for (int i = 0; i < 12; i++)
      cyc(0, SEL, 0, 0, 2'b00, AW'(i), (i == 0) ? '0 : pat(i-1), 0, "R3 fill");
    cyc(0, SEL, 1, 0, 2'b00, 4'd0, pat(11), 0, "R4 read after write stream");
    for (int i = 1; i < 12; i++)
      cyc(0, SEL, 1, 0, 2'b11, AW'(i), '0, 0, "R11 flow-through read");

    // lane strobes, read issued on the data edge
    cyc(0, SEL, 0, 0, 2'b11, 4'd3, '0, 0, "R6 write data cycle");
    cyc(0, SEL, 1, 0, 2'b10, 4'd3, 18'h3_0155, 0, "R4 lane0 merge read");
    cyc(0, SEL, 0, 0, 2'b11, 4'd4, '0, 0, "R6 write data cycle");
    cyc(0, SEL, 1, 0, 2'b01, 4'd4, 18'h2_AA00, 0, "R3 lane1 only");
    cyc(0, SEL, 0, 0, 2'b11, 4'd5, '0, 0, "R6 write data cycle");
    cyc(0, SEL, 1, 0, 2'b11, 4'd5, 18'h3_FFFF, 0, "R3 no lanes");
    cyc(0, SEL, 1, 0, 2'b11, 4'd3, '0, 0, "R3 lane0 after commit");

    // stall on a write data edge
    cyc(0, SEL, 0, 0, 2'b11, 4'd2, '0, 0, "R6 write data cycle");
    cyc(1, 3'b110, 1, 0, 2'b00, 4'd7, 18'h0_0BAD, 0, "R5 stalled write edge");
    cyc(0, SEL, 1, 0, 2'b00, 4'd2, 18'h1_C3C3, 0, "R5 data on next edge");
    // stall during read
    cyc(1, 3'b000, 0, 1, 2'b00, 4'd9, '0, 0, "R5 stalled read");
    cyc(0, SEL, 1, 0, 2'b11, 4'd2, '0, 0, "R5 read after stall");

    // unclocked output enable
    @(posedge clk); #3;
    out_en_ni = 1'b1;
    #1 check("R8 oe high mid cycle", 32'(rdata_oe_o), 32'd0);
    out_en_ni = 1'b0;
    #1 check("R8 oe low mid cycle", 32'(rdata_oe_o), 32'd1);

    // deselect variants and first cycle after
    cyc(0, 3'b110, 1, 0, 2'b11, 4'd1, '0, 0, "R2 desel sel1");
    cyc(0, 3'b000, 1, 0, 2'b11, 4'd1, '0, 0, "R2 desel sel2");
    cyc(0, 3'b011, 1, 0, 2'b11, 4'd1, '0, 0, "R2 desel sel3");
    cyc(0, SEL, 1, 1, 2'b11, 4'd1, '0, 0, "R9 advance while deselected");
    cyc(0, SEL, 1, 0, 2'b11, 4'd1, '0, 0, "R7 first after deselect");
    cyc(0, SEL, 1, 0, 2'b11, 4'd1, '0, 0, "R7 second read drives");

    // read burst, type and selects ignored on continuation
    cyc(0, SEL, 1, 0, 2'b11, 4'd6, '0, 0, "R11 burst start");
    cyc(0, 3'b110, 0, 1, 2'b00, 4'd7, '0, 0, "R9 read burst continues");
    cyc(0, 3'b000, 0, 1, 2'b00, 4'd4, '0, 0, "R9 read burst continues");
    // write burst
    cyc(0, SEL, 0, 0, 2'b11, 4'd12, '0, 0, "R6 write burst start");
    cyc(0, 3'b110, 1, 1, 2'b00, 4'd13, 18'h0_1234, 0, "R9 write burst continues");
    cyc(0, SEL, 1, 1, 2'b00, 4'd14, 18'h2_4321, 0, "R9 write burst continues");
    cyc(0, SEL, 1, 0, 2'b00, 4'd12, 18'h3_5678, 0, "R9 burst word 0");
    cyc(0, SEL, 1, 0, 2'b11, 4'd13, '0, 0, "R9 burst word 1");
    cyc(0, SEL, 1, 0, 2'b11, 4'd14, '0, 0, "R9 burst word 2");
    cyc(0, SEL, 1, 0, 2'b11, 4'd14, '0, 1, "R8 read with oe off");

    cyc(1, SEL, 1, 0, 2'b11, 4'd0, '0, 0, "drain", 1'b0);
    cyc(1, SEL, 1, 0, 2'b11, 4'd0, '0, 0, "drain", 1'b0);
    @(posedge clk); #3;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule